// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Timer

This block is a timer that produces edge-aligned pulse-width-modulated outputs on up to six pins. A single up-counter, a power-of-two prescaler and a 16-bit period limit are common to every channel. Each channel has its own compare value, which sets how long its pin stays in the active phase of each period. Each channel also has a mode/level selection that makes its pin high-true, low-true or off. Software programs the block through a small register window with a select, a write strobe, an 8-bit byte address and a data word equal to the counter width. Read data comes back combinationally from the addressed register.

The counter is sequenced by a two-state machine. In state `CNT_IDLE` the counter is stopped. In state `CNT_RUN` it counts. Transition GO (`CNT_IDLE` to `CNT_RUN`) happens when the clock-mode field is written as 01. Transition HALT (`CNT_RUN` to `CNT_IDLE`) happens when that field is written with any other value. Both transitions force every enabled channel pin to its active level.

While the counter runs, writes to the period limit and to the compare values go to holding registers. The new values are transferred at the next reload, so a period is never cut short. While the counter is stopped, those writes take effect at once.

Top module: `shared_pwm_timer`

## Requirements
- R1: After reset the counter reads 0, the control register reads 0, the period register reads 0xFFFF, every channel control register reads 0 and every pin is low.
- R2: The register at byte address 0x08 returns the number of implemented channels in bits [7:0] and zero above. Writes to it are ignored.
- R3: The control register at 0x10 holds the prescale exponent in bits [2:0] and the clock mode in bits [4:3], and both read back as written. Bit 5 and above always read 0. Clock mode 01 runs the counter. Any other clock-mode value stops the counter, and a stopped counter holds its value.
- R4: While running, the counter advances once every 2^P clock cycles, where P is the prescale exponent.
- R5: The counter at 0x14 counts from 0 up to the active period limit and then returns to 0, so one period lasts (limit+1) counter steps. The counter register is read-only.
- R6: A write to the period register at 0x18 becomes active at once while the counter is stopped. While the counter is running it becomes active only at the next reload. Reads return the last written value.
- R7: The channel n control register sits at 0x20+8n. Its layout is: bit 7 flag, bit 5 mode-high (MB), bit 4 mode-low (MA), bit 3 level-high (LB), bit 2 level-low (LA). MB:MA = 10 with LB:LA = 10 gives a high-true pin. MB:MA = 10 with LB:LA = 01 gives a low-true pin. Every other combination holds the pin low.
- R8: After the first counter step following a start, a high-true pin is high exactly while the counter is below the channel compare value. A low-true pin is the inverse of that.
- R9: A compare value of 0 gives no active phase. A compare value above the period limit gives an active phase that covers the whole period.
- R10: The channel n compare value at 0x24+8n becomes active at once while the counter is stopped. While the counter is running it becomes active at the next reload. Reads return the last written value.
- R11: In the same clock edge in which any of the following happens, an enabled channel pin goes to its active level (high for high-true, low for low-true):
  - a write to that channel's control register;
  - a start of the counter;
  - a pause of the counter.
- R12: A channel flag sets when the counter steps onto that channel's compare value. Writing 1 to bit 7 clears the flag. If a set and a clear happen in the same cycle, the set wins.
- R13: Addresses of channels at or above the implemented count read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data of the addressed register (combinational) |
| pwm_out | output | NCH | One PWM pin per channel |

## Verification
The bench sweeps the compare value across and past a short period, with mixed polarities, and counts active cycles over one period. A design that compared with the wrong bound, or let reload win over match, would show an off-by-one duty or a one-cycle glitch at value 0. The bench measures both high time and period for each prescale exponent up to 3; a divider terminal count off by one would stretch both. It writes the period limit and a compare value mid-period and checks the old values still govern the current period, which catches a design that loads them at once. It also catches pins that are not forced on a mode write or pause, a flag that does not clear, reserved mode combinations that drive the pin, and phantom channels above the implemented count.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    // Register window (byte addresses)
    localparam int          REG_AW      = 8;
    localparam logic [7:0]  OFS_GLOBAL  = 8'h08;
    localparam logic [7:0]  OFS_CTRL    = 8'h10;
    localparam logic [7:0]  OFS_COUNT   = 8'h14;
    localparam logic [7:0]  OFS_PERIOD  = 8'h18;
    localparam logic [7:0]  OFS_CH_BASE = 8'h20;
    localparam logic [7:0]  CH_STRIDE   = 8'h08;
    localparam logic [7:0]  OFS_CH_VAL  = 8'h04;

    // Control register fields
    localparam int          CTRL_PS_LSB = 0;
    localparam int          CTRL_CM_LSB = 3;
    localparam int          CTRL_CM_W   = 2;
    localparam logic [1:0]  CM_RUN      = 2'b01;

    // Channel control register bit positions
    localparam int CH_FLAG_BIT = 7;
    localparam int CH_MB_BIT   = 5;
    localparam int CH_MA_BIT   = 4;
    localparam int CH_LB_BIT   = 3;
    localparam int CH_LA_BIT   = 2;

    typedef enum logic [0:0] {
        CNT_IDLE = 1'b0,
        CNT_RUN  = 1'b1
    } cnt_state_e;

    typedef struct packed {
        logic mb;
        logic ma;
        logic lb;
        logic la;
    } ch_mode_t;

    typedef enum logic [1:0] {
        OUT_OFF       = 2'd0,
        OUT_HIGH_TRUE = 2'd1,
        OUT_LOW_TRUE  = 2'd2
    } out_kind_e;

    function automatic out_kind_e decode_mode(input ch_mode_t m);
        if ({m.mb, m.ma} != 2'b10)      return OUT_OFF;
        else if ({m.lb, m.la} == 2'b10) return OUT_HIGH_TRUE;
        else if ({m.lb, m.la} == 2'b01) return OUT_LOW_TRUE;
        else                            return OUT_OFF;
    endfunction

    function automatic logic [7:0] ch_csr_addr(input int idx);
        return OFS_CH_BASE + 8'(idx) * CH_STRIDE;
    endfunction

    function automatic logic [7:0] ch_val_addr(input int idx);
        return OFS_CH_BASE + 8'(idx) * CH_STRIDE + OFS_CH_VAL;
    endfunction

endpackage

// File: rtl/pwm_timer_counter.sv
module pwm_timer_counter
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PS_W  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_wr,
    input  logic [PS_W-1:0]      ctrl_ps,
    input  logic [CTRL_CM_W-1:0] ctrl_cm,
    input  logic                 period_wr,
    input  logic [CNT_W-1:0]     period_wdata,
    output logic                 running,
    output logic                 force_lvl,
    output logic                 tick,
    output logic                 reload,
    output logic [CNT_W-1:0]     cnt,
    output logic [CNT_W-1:0]     next_cnt,
    output logic [CNT_W-1:0]     mod_act,
    output logic [CNT_W-1:0]     mod_buf,
    output logic [PS_W-1:0]      ps_q,
    output logic [CTRL_CM_W-1:0] cm_q
);

    localparam int DIV_W = (1 << PS_W) - 1;

    cnt_state_e       state_q, state_d;
    logic             go, halt;
    logic [DIV_W-1:0] div_q, div_lim;

    // Next-state and transition decode
    always_comb begin
        state_d = state_q;
        go      = 1'b0;
        halt    = 1'b0;
        unique case (state_q)
            CNT_IDLE: begin
                if (ctrl_wr && ctrl_cm == CM_RUN) begin
                    state_d = CNT_RUN;
                    go      = 1'b1;
                end
            end
            CNT_RUN: begin
                if (ctrl_wr && ctrl_cm != CM_RUN) begin
                    state_d = CNT_IDLE;
                    halt    = 1'b1;
                end
            end
            default: state_d = CNT_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CNT_IDLE;
        else        state_q <= state_d;
    end

    // Outputs of the sequencer
    always_comb begin
        running   = (state_q == CNT_RUN);
        force_lvl = go | halt;
        div_lim   = ~({DIV_W{1'b1}} << ps_q);
        tick      = running && (div_q == div_lim);
        reload    = tick && (cnt == mod_act);
        next_cnt  = reload ? '0 : cnt + CNT_W'(1);
    end

    // Control fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= '0;
            cm_q <= '0;
        end else if (ctrl_wr) begin
            ps_q <= ctrl_ps;
            cm_q <= ctrl_cm;
        end
    end

    // Prescale divider
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 div_q <= '0;
        else if (!running || ctrl_wr || tick) div_q <= '0;
        else                        div_q <= div_q + DIV_W'(1);
    end

    // Counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= next_cnt;
    end

    // Period limit with reload-time transfer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_buf <= '1;
            mod_act <= '1;
        end else begin
            if (period_wr) mod_buf <= period_wdata;
            if (period_wr && !running) mod_act <= period_wdata;
            else if (reload)           mod_act <= mod_buf;
        end
    end

endmodule

// File: rtl/pwm_timer_channel.sv
module pwm_timer_channel
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             tick,
    input  logic             reload,
    input  logic             force_all,
    input  logic [CNT_W-1:0] next_cnt,
    input  logic             csr_wr,
    input  logic             csr_wflag,
    input  ch_mode_t         csr_wmode,
    input  logic             val_wr,
    input  logic [CNT_W-1:0] val_wdata,
    output logic [7:0]       csr_rd,
    output logic [CNT_W-1:0] val_rd,
    output logic             pwm
);

    ch_mode_t         mode_q;
    logic             flag_q;
    logic             phase_q;
    logic [CNT_W-1:0] val_buf, val_act, cmp_val;
    logic             match;

    always_comb begin
        cmp_val = reload ? val_buf : val_act;
        match   = tick && (next_cnt == cmp_val);
    end

    // Mode bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mode_q <= '0;
        else if (csr_wr) mode_q <= csr_wmode;
    end

    // Flag: set by match, cleared by write-one; set wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     flag_q <= 1'b0;
        else if (match)                 flag_q <= 1'b1;
        else if (csr_wr && csr_wflag)   flag_q <= 1'b0;
    end

    // Compare value with reload-time transfer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_buf <= '0;
            val_act <= '0;
        end else begin
            if (val_wr) val_buf <= val_wdata;
            if (val_wr && !running) val_act <= val_wdata;
            else if (reload)        val_act <= val_buf;
        end
    end

    // Active-phase bit: forced, cleared on match, set on reload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  phase_q <= 1'b0;
        else if (force_all || csr_wr) phase_q <= 1'b1;
        else if (match)              phase_q <= 1'b0;
        else if (reload)             phase_q <= 1'b1;
    end

    // Pin and readback
    always_comb begin
        unique case (decode_mode(mode_q))
            OUT_HIGH_TRUE: pwm = phase_q;
            OUT_LOW_TRUE:  pwm = ~phase_q;
            default:       pwm = 1'b0;
        endcase
        csr_rd = '0;
        csr_rd[CH_FLAG_BIT] = flag_q;
        csr_rd[CH_MB_BIT]   = mode_q.mb;
        csr_rd[CH_MA_BIT]   = mode_q.ma;
        csr_rd[CH_LB_BIT]   = mode_q.lb;
        csr_rd[CH_LA_BIT]   = mode_q.la;
        val_rd = val_buf;
    end

endmodule

// File: rtl/shared_pwm_timer.sv
module shared_pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int NCH   = 6,
    parameter int CNT_W = 16,
    parameter int PS_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NCH-1:0]    pwm_out
);

    localparam int DATA_W = CNT_W;

    logic                 wr;
    logic                 ctrl_wr, period_wr;
    logic                 running, force_lvl, cnt_tick, cnt_reload;
    logic [CNT_W-1:0]     cnt_value, next_cnt, mod_active, mod_buf;
    logic [PS_W-1:0]      ps_q;
    logic [CTRL_CM_W-1:0] cm_q;
    ch_mode_t             wr_mode;

    logic [7:0]       ch_csr_rd [NCH];
    logic [CNT_W-1:0] ch_val_rd [NCH];

    always_comb begin
        wr        = bus_sel && bus_we;
        ctrl_wr   = wr && (bus_addr == OFS_CTRL);
        period_wr = wr && (bus_addr == OFS_PERIOD);
        wr_mode   = '{mb: bus_wdata[CH_MB_BIT], ma: bus_wdata[CH_MA_BIT],
                      lb: bus_wdata[CH_LB_BIT], la: bus_wdata[CH_LA_BIT]};
    end

    pwm_timer_counter #(.CNT_W(CNT_W), .PS_W(PS_W)) u_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr      (ctrl_wr),
        .ctrl_ps      (bus_wdata[CTRL_PS_LSB +: PS_W]),
        .ctrl_cm      (bus_wdata[CTRL_CM_LSB +: CTRL_CM_W]),
        .period_wr    (period_wr),
        .period_wdata (bus_wdata),
        .running      (running),
        .force_lvl    (force_lvl),
        .tick         (cnt_tick),
        .reload       (cnt_reload),
        .cnt          (cnt_value),
        .next_cnt     (next_cnt),
        .mod_act      (mod_active),
        .mod_buf      (mod_buf),
        .ps_q         (ps_q),
        .cm_q         (cm_q)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam logic [7:0] CSR_A = ch_csr_addr(i);
        localparam logic [7:0] VAL_A = ch_val_addr(i);
        logic csr_wr_i, val_wr_i;
        assign csr_wr_i = wr && (bus_addr == CSR_A);
        assign val_wr_i = wr && (bus_addr == VAL_A);

        pwm_timer_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .running   (running),
            .tick      (cnt_tick),
            .reload    (cnt_reload),
            .force_all (force_lvl),
            .next_cnt  (next_cnt),
            .csr_wr    (csr_wr_i),
            .csr_wflag (bus_wdata[CH_FLAG_BIT]),
            .csr_wmode (wr_mode),
            .val_wr    (val_wr_i),
            .val_wdata (bus_wdata),
            .csr_rd    (ch_csr_rd[i]),
            .val_rd    (ch_val_rd[i]),
            .pwm       (pwm_out[i])
        );
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_GLOBAL)      bus_rdata = DATA_W'(NCH);
        else if (bus_addr == OFS_CTRL)   bus_rdata = DATA_W'({cm_q, ps_q});
        else if (bus_addr == OFS_COUNT)  bus_rdata = cnt_value;
        else if (bus_addr == OFS_PERIOD) bus_rdata = mod_buf;
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == ch_csr_addr(i)) bus_rdata = DATA_W'(ch_csr_rd[i]);
            if (bus_addr == ch_val_addr(i)) bus_rdata = ch_val_rd[i];
        end
    end

endmodule

// File: rtl/pwm_timer_checker.sv
module pwm_timer_checker
    import pwm_timer_pkg::*;
#(
    parameter int NCH   = 6,
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              running,
    input logic              reload,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  mod_act,
    input logic              period_wr,
    input logic [CNT_W-1:0]  period_wdata,
    input logic [REG_AW-1:0] bus_addr,
    input logic [CNT_W-1:0]  bus_rdata
);

    assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(running) |-> $stable(cnt));

    assert_ctrl_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_CTRL) |-> (bus_rdata[CNT_W-1:5] == '0));

    assert_global_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_GLOBAL) |-> (bus_rdata == CNT_W'(NCH)));

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(running) && (cnt != $past(cnt)))
            |-> ((cnt == CNT_W'($past(cnt) + CNT_W'(1))) || (cnt == '0)));

    assert_reload_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reload) |-> (cnt == '0));

    assert_period_immediate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (period_wr && !running) |=> (mod_act == $past(period_wdata)));

    assert_period_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (period_wr && running && !reload) |=> $stable(mod_act));

endmodule

bind shared_pwm_timer pwm_timer_checker #(.NCH(NCH), .CNT_W(CNT_W)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .running      (running),
    .reload       (cnt_reload),
    .cnt          (cnt_value),
    .mod_act      (mod_active),
    .period_wr    (period_wr),
    .period_wdata (bus_wdata),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata)
);

// File: tb/shared_pwm_timer_test.sv
module shared_pwm_timer_test;

    localparam int NCH = 3;
    localparam logic [7:0] A_GLB = 8'h08, A_CTL = 8'h10, A_CNT = 8'h14, A_MOD = 8'h18;
    localparam logic [15:0] HI_TRUE = 16'h0028, LO_TRUE = 16'h0024, RUN = 16'h0008;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [NCH-1:0] pwm_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    shared_pwm_timer #(.NCH(NCH), .CNT_W(16), .PS_W(3)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out)
    );

    function automatic logic [7:0] csr_a(input int i); return 8'h20 + 8'(8 * i); endfunction
    function automatic logic [7:0] val_a(input int i); return 8'h24 + 8'(8 * i); endfunction
    function automatic int min_i(input int a, input int b); return (a < b) ? a : b; endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int d);
        bus_addr = a;
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic wait_count(input int v);
        int d;
        for (int k = 0; k < 2000; k++) begin
            rd(A_CNT, d);
            if (d == v) break;
            @(negedge clk);
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int d, c0, c1, c2, hi, per, a0, cv2;
        logic prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pins", int'(pwm_out), 0);
        rd(A_CNT, d); chk("R1 counter", d, 0);
        rd(A_CTL, d); chk("R1 control", d, 0);
        rd(A_MOD, d); chk("R1 period", d, 16'hFFFF);
        rd(csr_a(0), d); chk("R1 channel csr", d, 0);

        // R2 channel count, read-only
        rd(A_GLB, d); chk("R2 count", d, NCH);
        wr(A_GLB, 16'h00FF);
        rd(A_GLB, d); chk("R2 write ignored", d, NCH);

        // R3 field readback, bit 5 dropped, mode 11 stays stopped
        wr(A_CTL, 16'h003F);
        rd(A_CTL, d); chk("R3 readback", d, 16'h001F);
        repeat (300) @(negedge clk);
        rd(A_CNT, d); chk("R3 mode 11 stopped", d, 0);
        wr(A_CTL, 16'h0000);

        // R13 unimplemented channel
        wr(csr_a(3), HI_TRUE);
        wr(val_a(3), 16'h0005);
        rd(csr_a(3), d); chk("R13 csr", d, 0);
        rd(val_a(3), d); chk("R13 value", d, 0);

        // R8 / R9 duty sweep, limit 5 written while stopped
        wr(A_MOD, 16'd5);
        for (int cv = 0; cv < 8; cv++) begin
            cv2 = (cv + 3) % 8;
            wr(A_CTL, 16'h0000);
            wr(val_a(0), 16'(cv));
            wr(val_a(1), 16'(cv));
            wr(val_a(2), 16'(cv2));
            wr(csr_a(0), HI_TRUE);
            wr(csr_a(1), LO_TRUE);
            wr(csr_a(2), HI_TRUE);
            wr(A_CTL, RUN);
            repeat (12) @(negedge clk);
            c0 = 0; c1 = 0; c2 = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                c0 += int'(pwm_out[0]); c1 += int'(pwm_out[1]); c2 += int'(pwm_out[2]);
            end
            a0 = min_i(cv, 6);
            if (cv == 0 || cv > 5) begin
                chk("R9 high-true duty", c0, a0);
                chk("R9 low-true duty", c1, 6 - a0);
            end else begin
                chk("R8 high-true duty", c0, a0);
                chk("R8 low-true duty", c1, 6 - a0);
            end
            chk("R8 third channel duty", c2, min_i(cv2, 6));
        end

        // R4 / R5 prescaler sweep, limit 3, value 1
        for (int p = 0; p < 4; p++) begin
            wr(A_CTL, 16'(p));
            wr(A_MOD, 16'd3);
            wr(val_a(0), 16'd1);
            wr(csr_a(0), HI_TRUE);
            wr(A_CTL, RUN | 16'(p));
            prev = 1'b1;
            for (int k = 0; k < 500; k++) begin
                @(negedge clk);
                if (!prev && pwm_out[0]) break;
                prev = pwm_out[0];
            end
            hi = 0;
            for (int k = 0; k < 500 && pwm_out[0]; k++) begin hi++; @(negedge clk); end
            per = hi;
            for (int k = 0; k < 500 && !pwm_out[0]; k++) begin per++; @(negedge clk); end
            chk("R4 high time", hi, 1 << p);
            chk("R5 period length", per, 4 << p);
        end

        // R6 period write while running is held to the reload
        wr(A_CTL, 16'h0000);
        wr(A_MOD, 16'd5);
        wr(val_a(0), 16'd2);
        wr(csr_a(0), HI_TRUE);
        wr(A_CTL, RUN);
        repeat (10) @(negedge clk);
        wr(A_MOD, 16'd9);
        begin
            int prev_c, first_top, max_late;
            first_top = -1; max_late = 0;
            rd(A_CNT, prev_c);
            for (int k = 1; k < 30; k++) begin
                @(negedge clk);
                rd(A_CNT, d);
                if (d == 0 && prev_c != 0 && first_top < 0) first_top = prev_c;
                if (k >= 15 && d > max_late) max_late = d;
                prev_c = d;
            end
            chk("R6 old limit finishes period", first_top, 5);
            chk("R6 new limit after reload", max_late, 9);
        end
        rd(A_MOD, d); chk("R6 period readback", d, 9);

        // R10 compare value held until reload
        wait_count(3);
        wr(val_a(0), 16'd7);
        chk("R10 old value still active", int'(pwm_out[0]), 0);
        rd(val_a(0), d); chk("R10 value readback", d, 7);
        wait_count(0);
        wait_count(4);
        chk("R10 new value after reload", int'(pwm_out[0]), 1);

        // R11 forcing on channel write and on pause
        wait_count(8);
        wr(csr_a(0), HI_TRUE);
        chk("R11 forced by csr write", int'(pwm_out[0]), 1);
        wait_count(8);
        chk("R8 inactive past value", int'(pwm_out[0]), 0);
        wr(A_CTL, 16'h0000);
        chk("R11 pause forces high-true", int'(pwm_out[0]), 1);
        chk("R11 pause forces low-true", int'(pwm_out[1]), 0);
        rd(A_CNT, d); chk("R3 paused value", d, 9);
        repeat (5) @(negedge clk);
        rd(A_CNT, d); chk("R3 pause holds", d, 9);
        wr(A_CNT, 16'h0055);
        rd(A_CNT, d); chk("R5 counter read-only", d, 9);

        // R12 flag set, clear, set again
        rd(csr_a(0), d); chk("R12 flag set", d, 16'h00A8);
        wr(csr_a(0), 16'h00A8);
        rd(csr_a(0), d); chk("R12 flag cleared", d, 16'h0028);
        wr(A_CTL, RUN);
        repeat (15) @(negedge clk);
        rd(csr_a(0), d); chk("R12 flag set again", d, 16'h00A8);

        // R7 reserved combinations keep pin low
        wr(val_a(2), 16'd5);
        wr(csr_a(2), 16'h002C);
        repeat (25) @(negedge clk);
        c2 = 0;
        for (int k = 0; k < 10; k++) begin @(negedge clk); c2 += int'(pwm_out[2]); end
        chk("R7 level 11 off", c2, 0);
        wr(csr_a(2), 16'h0018);
        repeat (12) @(negedge clk);
        c2 = 0;
        for (int k = 0; k < 10; k++) begin @(negedge clk); c2 += int'(pwm_out[2]); end
        chk("R7 mode 01 off", c2, 0);
        rd(csr_a(2), d); chk("R7 layout readback", d & 16'h003C, 16'h0018);
        wr(csr_a(2), HI_TRUE);
        repeat (12) @(negedge clk);
        c2 = 0;
        for (int k = 0; k < 10; k++) begin @(negedge clk); c2 += int'(pwm_out[2]); end
        chk("R7 high-true enabled duty", c2, 5);

        summary();
        $finish;
    end

endmodule